// File: doc/BRIEF.md
# Programmable Channel Scan Sequencer

This block produces the 4-bit channel select for an analog input multiplexer that feeds a converter. The host writes a single 16-bit control word. The word holds two channel bounds and a set of mode fields: the range code, the input wiring (single-ended or differential), the polarity (unipolar or bipolar) and the pacer source. The block keeps the mode fields and drives them out unchanged. Any agent on the bus can read the whole word back.

A write moves the multiplexer to the low bound at once. After that, every conversion-done pulse advances the channel by one. When the channel leaves the high bound it returns to the low bound. If the high bound is numerically below the low bound, the channel counts upward through 15, rolls over to 0, and continues until it meets the high bound. If the two bounds are equal, the scan stays on that single channel.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset, `chan`, `rd_data`, `gain`, `diff_sel`, `bipolar` and `pacer_src` are all zero.
- R2: The cycle after a write, `rd_data` returns the written bits 13:0, and bits 15:14 read as 0.
- R3: A write sets `chan` to the written low bound (bits 3:0) in the following cycle.
- R4: A conversion-done pulse while `chan` differs from the high bound (bits 7:4) makes `chan` one greater, modulo 16, in the next cycle.
- R5: A conversion-done pulse while `chan` equals the high bound loads the low bound into `chan` in the next cycle.
- R6: When the low and high bounds are equal, conversion-done pulses leave `chan` on that channel.
- R7: When the high bound is below the low bound, the scan goes from 15 to 0 and reloads the low bound only after the high bound.
- R8: A conversion-done pulse in the same cycle as a write is ignored, and `chan` takes the written low bound.
- R9: The mode outputs follow the stored word: `gain` is bits 9:8, `diff_sel` is bit 10, `bipolar` is bit 11 and `pacer_src` is bits 13:12. Conversion-done pulses do not change them.
- R10: With no write and no conversion-done pulse, `chan` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| conv_done | input | 1 | One-cycle pulse marking a finished conversion |
| rd_data | output | 16 | Readback of the stored control word |
| chan | output | 4 | Current multiplexer channel |
| gain | output | 2 | Stored range code |
| diff_sel | output | 1 | 1 selects differential input |
| bipolar | output | 1 | 1 selects bipolar range |
| pacer_src | output | 2 | Stored pacer source select |

## Verification
The hardest case to reach is a reversed window. This is a window whose high bound is below its low bound. The scan has to cross the 15-to-0 rollover and must not reload early, and this has to hold while writes and conversion pulses land in the same cycle. Directed writes set up reversed windows, single-channel windows and full windows, and each is followed by enough pulses to pass the rollover. A long random phase then mixes writes, pulses and collisions between the two. A behavioural model checks every cycle of this phase.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int CH_W    = 4;
  localparam int REG_W   = 16;
  localparam int GAIN_W  = 2;
  localparam int PACER_W = 2;
  localparam int CFG_W   = 2 * CH_W + GAIN_W + 2 + PACER_W;

  typedef struct packed {
    logic [PACER_W-1:0] pacer;
    logic               bipolar;
    logic               diff;
    logic [GAIN_W-1:0]  gain;
    logic [CH_W-1:0]    hi;
    logic [CH_W-1:0]    lo;
  } scan_cfg_t;

  function automatic logic at_stop(input logic [CH_W-1:0] cur,
                                   input logic [CH_W-1:0] hi);
    return cur == hi;
  endfunction

  function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] cur,
                                                input logic [CH_W-1:0] lo,
                                                input logic [CH_W-1:0] hi);
    if (at_stop(cur, hi)) return lo;
    return cur + CH_W'(1);
  endfunction
endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_bits,
  output scan_cfg_t        cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= scan_cfg_t'(wr_bits);
  end
endmodule

// File: rtl/scan_chan_ctr.sv
module scan_chan_ctr
  import scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_val,
  input  logic            advance,
  input  logic [CH_W-1:0] lo,
  input  logic [CH_W-1:0] hi,
  output logic [CH_W-1:0] chan,
  output logic            step_evt,
  output logic            wrap_evt
);
  assign wrap_evt = !load && advance && at_stop(chan, hi);
  assign step_evt = !load && advance && !at_stop(chan, hi);

  always_ff @(posedge clk) begin
    if (!rst_n)       chan <= '0;
    else if (load)    chan <= load_val;
    else if (advance) chan <= next_chan(chan, lo, hi);
  end
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               conv_done,
  output logic [REG_W-1:0]   rd_data,
  output logic [CH_W-1:0]    chan,
  output logic [GAIN_W-1:0]  gain,
  output logic               diff_sel,
  output logic               bipolar,
  output logic [PACER_W-1:0] pacer_src
);
  localparam int PAD_W = REG_W - CFG_W;

  scan_cfg_t cfg;
  logic      step_evt;
  logic      wrap_evt;
  logic      unused_top_bits;

  assign unused_top_bits = ^wr_data[REG_W-1:CFG_W];

  scan_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_bits(wr_data[CFG_W-1:0]),
    .cfg    (cfg)
  );

  scan_chan_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_en),
    .load_val(wr_data[CH_W-1:0]),
    .advance (conv_done),
    .lo      (cfg.lo),
    .hi      (cfg.hi),
    .chan    (chan),
    .step_evt(step_evt),
    .wrap_evt(wrap_evt)
  );

  assign rd_data   = {{PAD_W{1'b0}}, cfg};
  assign gain      = cfg.gain;
  assign diff_sel  = cfg.diff;
  assign bipolar   = cfg.bipolar;
  assign pacer_src = cfg.pacer;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
  import scan_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic               conv_done,
  input logic [REG_W-1:0]   rd_data,
  input logic [CH_W-1:0]    chan,
  input logic [GAIN_W-1:0]  gain,
  input logic               diff_sel,
  input logic               bipolar,
  input logic [PACER_W-1:0] pacer_src,
  input logic               step_evt,
  input logic               wrap_evt
);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {2'b00, $past(wr_data[13:0])});

  a_r3_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> chan == $past(wr_data[3:0]));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> chan == $past(chan) + 4'd1);

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> chan == $past(rd_data[3:0]));

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !wr_en && rd_data[3:0] == rd_data[7:4] && chan == rd_data[3:0])
      |=> $stable(chan));

  a_r8_event_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_evt, wrap_evt}) && !(wr_en && (step_evt || wrap_evt)));

  a_r9_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({gain, diff_sel, bipolar, pacer_src}));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !conv_done) |=> $stable(chan));
endmodule

bind chan_scan_seq scan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .conv_done(conv_done), .rd_data(rd_data), .chan(chan), .gain(gain),
  .diff_sel(diff_sel), .bipolar(bipolar), .pacer_src(pacer_src),
  .step_evt(step_evt), .wrap_evt(wrap_evt)
);

// File: tb/tb_chan_scan_seq.sv
module tb_chan_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        conv_done = 1'b0;
  logic [15:0] rd_data;
  logic [3:0]  chan;
  logic [1:0]  gain;
  logic        diff_sel;
  logic        bipolar;
  logic [1:0]  pacer_src;

  int    total = 0;
  int    bad = 0;
  string cur_tag = "R1";
  int    m_word = 0;
  int    m_chan = 0;

  always #4 clk = ~clk;

  chan_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_done(conv_done), .rd_data(rd_data), .chan(chan), .gain(gain),
    .diff_sel(diff_sel), .bipolar(bipolar), .pacer_src(pacer_src)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference, updated at the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 0;
      m_chan = 0;
    end else if (wr_en) begin
      m_word = int'(wr_data) % 16384;
      m_chan = int'(wr_data) % 16;
    end else if (conv_done) begin
      if (m_chan == (m_word / 16) % 16) m_chan = m_word % 16;
      else m_chan = (m_chan + 1) % 16;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_tag, "chan", int'(chan), m_chan);
      check("R2", "rd_data", int'(rd_data), m_word);
      check("R9", "gain", int'(gain), (m_word / 256) % 4);
      check("R9", "diff_sel", int'(diff_sel), (m_word / 1024) % 2);
      check("R9", "bipolar", int'(bipolar), (m_word / 2048) % 2);
      check("R9", "pacer_src", int'(pacer_src), (m_word / 4096) % 4);
    end
  end

  task automatic do_write(input logic [15:0] d, input logic with_conv);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; conv_done = with_conv;
    @(negedge clk);
    wr_en = 1'b0; conv_done = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); conv_done = 1'b1;
      @(negedge clk); conv_done = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "chan", int'(chan), 0);
    check("R1", "rd_data", int'(rd_data), 0);
    check("R1", "modes", int'({gain, diff_sel, bipolar, pacer_src}), 0);
    rst_n = 1'b1;

    cur_tag = "R3";
    do_write(16'hF2_52, 1'b0);      // lo=2 hi=5, top bits set
    check("R3", "chan after write", int'(chan), 2);
    check("R2", "top bits zero", int'(rd_data[15:14]), 0);
    cur_tag = "R4";
    pulse(3);
    check("R4", "chan step", int'(chan), 5);
    cur_tag = "R5";
    pulse(1);
    check("R5", "wrap to lo", int'(chan), 2);
    cur_tag = "R10";
    repeat (5) @(negedge clk);
    check("R10", "idle hold", int'(chan), 2);

    cur_tag = "R6";
    do_write(16'h2D77, 1'b0);       // lo=hi=7, mode bits varied
    pulse(4);
    check("R6", "single channel", int'(chan), 7);
    check("R9", "gain field", int'(gain), 1);
    check("R9", "diff field", int'(diff_sel), 1);
    check("R9", "bipolar field", int'(bipolar), 1);
    check("R9", "pacer field", int'(pacer_src), 2);

    cur_tag = "R7";
    do_write(16'h001E, 1'b0);       // lo=14 hi=1
    pulse(1); check("R7", "14->15", int'(chan), 15);
    pulse(1); check("R7", "15->0", int'(chan), 0);
    pulse(1); check("R7", "0->1", int'(chan), 1);
    pulse(1); check("R7", "1->14", int'(chan), 14);

    cur_tag = "R8";
    do_write(16'h0093, 1'b1);       // lo=3 hi=9 with simultaneous pulse
    check("R8", "collision keeps lo", int'(chan), 3);
    do_write(16'h00F0, 1'b0);       // full window 0..15
    pulse(16);
    check("R4", "full window wraps", int'(chan), 0);

    cur_tag = "R4 R5 R7 R8";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en     = ($urandom % 23) == 0;
      wr_data   = 16'($urandom);
      conv_done = ($urandom % 3) != 0;
    end
    @(negedge clk);
    wr_en = 1'b0; conv_done = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule